// File: doc/BRIEF.md
# SPI Flash Slave Command Front End

This block is the serial side of a flash-style memory slave. It oversamples the chip select, serial clock, serial input and hold pins with the system clock. Input bits are taken on rising serial-clock edges and output bits are launched on falling edges. The block accepts both idle levels of the serial clock. It frames each selection into an 8-bit command code, a 24-bit location and a run of data bytes. Command codes it does not know are dropped.

For a known command it sends a one-cycle strobe, with the command class and the full location, to the array controller that sits beside it. It then streams bytes back until chip select is released. For a read, the bytes come from a byte store with an incrementing pointer that wraps at the top. For identification, two fixed bytes take turns. A hold pin freezes the selection in place without ending it. In this project a small read-only byte model with a computed fill stands in for the storage array.

Top module: `spi_flash_front`

## Requirements
- R1: After reset, `so_en` and `cmd_valid` are 0.
- R2: While `cs_n` is low, the first 32 rising `sck` edges capture `si` MSB first: 8 bits of command code, then 24 bits of location. When the code is 03h (read), 90h or ABh (identify), a single-cycle `cmd_valid` is raised after the 32nd edge. With it come `cmd_kind` (1 = read, 2 = identify) and `cmd_addr`, which holds all 24 received location bits.
- R3: After a read header, each falling `sck` edge launches one bit on `so`, MSB first, and `so_en` is 1. The first byte is the one at the received location. The store holds, at location L, the byte L[7:0] XOR L[15:8] XOR 5Ah. `so` changes only on falling edges.
- R4: The read pointer steps by one per byte and uses only the low ADDR_W bits of the location (8 by default). Past the top location it wraps to 0 and streaming goes on.
- R5: The serial clock may idle low or high while `cs_n` is high. Both give the same capture and the same output.
- R6: After an identify header, bytes alternate between the maker code (C2h) and the device code (3Dh). Location bit 0 = 0 starts with the maker code and bit 0 = 1 starts with the device code.
- R7: Any other command code raises no `cmd_valid` and leaves `so_en` at 0 until `cs_n` goes high.
- R8: If `cs_n` goes high before the 32nd rising edge, no `cmd_valid` is raised and the partial header is discarded. The next selection decodes normally.
- R9: `hold_n` low takes effect only while `sck` is low, and it is released only while `sck` is low. While it is in effect, `so_en` is 0 and `sck` and `si` have no effect. After release, capture and streaming resume with no bit lost.
- R10: A high `cs_n` ends the selection. A few clock cycles later `so_en` is 0, and the next selection starts a fresh header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Output enable for `so`; 0 means high impedance |
| cmd_valid | output | 1 | One-cycle strobe for a decoded command |
| cmd_kind | output | 2 | Command class: 1 read, 2 identify |
| cmd_addr | output | 24 | Location received with the command |

## Verification
On every cycle, the assertions check these properties. `so` moves only on a qualified falling edge. A dropped command code stays dropped for the rest of its selection. A hold freezes the header counter and can only change while `sck` is low. The strobe is a single cycle and never carries an unknown class. Deselection clears the stream. Only the bench's scenarios can show the data values themselves: the fill pattern, pointer wrap, identification byte order and both clock idle levels. The same holds for a hold in the middle of an address or data byte leaving the bits intact, and for a truncated header leaving no trace.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;

    localparam int BYTE_W    = 8;
    localparam int OP_BITS   = 8;
    localparam int ADDR_BITS = 24;
    localparam int HDR_BITS  = OP_BITS + ADDR_BITS;
    localparam int CNT_W     = $clog2(HDR_BITS + 1);
    localparam int BIT_W     = $clog2(BYTE_W);

    localparam logic [OP_BITS-1:0] OP_READ = 8'h03;
    localparam logic [OP_BITS-1:0] OP_ID_A = 8'h90;
    localparam logic [OP_BITS-1:0] OP_ID_B = 8'hAB;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_READ = 2'd1,
        CMD_ID   = 2'd2
    } cmd_kind_e;

    typedef enum logic [1:0] {
        PH_HDR    = 2'd0,
        PH_STREAM = 2'd1,
        PH_IGNORE = 2'd2
    } phase_e;

    typedef struct packed {
        logic cs_active;
        logic rise;
        logic fall;
        logic si;
        logic hold_act;
    } link_s;

    function automatic cmd_kind_e decode_op(input logic [OP_BITS-1:0] op);
        case (op)
            OP_READ:          return CMD_READ;
            OP_ID_A, OP_ID_B: return CMD_ID;
            default:          return CMD_NONE;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] fill_byte(input logic [15:0] loc);
        return loc[7:0] ^ loc[15:8] ^ 8'h5A;
    endfunction

endpackage

// File: rtl/spi_link_sync.sv
module spi_link_sync
    import spi_front_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_n,
    input  logic  sck,
    input  logic  si,
    input  logic  hold_n,
    output link_s lk
);
    localparam int NSIG = 4;
    // bit order {hold_n, si, sck, cs_n}
    localparam logic [NSIG-1:0] IDLE_LVL = 4'b1001;

    logic [NSIG-1:0] raw;
    logic [SYNC_STAGES-1:0][NSIG-1:0] stage;
    logic [NSIG-1:0] synced;
    logic sck_q, hold_q;
    logic cs_on, sck_s, si_s, hold_req;

    assign raw = {hold_n, si, sck, cs_n};

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) stage <= IDLE_LVL;
                else     stage <= raw;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stage <= {SYNC_STAGES{IDLE_LVL}};
                else     stage <= {stage[SYNC_STAGES-2:0], raw};
            end
        end
    endgenerate

    assign synced   = stage[SYNC_STAGES-1];
    assign cs_on    = ~synced[0];
    assign sck_s    = synced[1];
    assign si_s     = synced[2];
    assign hold_req = ~synced[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            sck_q <= sck_s;
            if (!cs_on)      hold_q <= 1'b0;
            else if (!sck_s) hold_q <= hold_req;
        end
    end

    always_comb begin
        lk.cs_active = cs_on;
        lk.rise      = cs_on & ~hold_q & sck_s & ~sck_q;
        lk.fall      = cs_on & ~hold_q & ~sck_s & sck_q;
        lk.si        = si_s;
        lk.hold_act  = hold_q;
    end

    AST_HOLD_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
        (sck_s && cs_on) |=> $stable(hold_q)); // R9

endmodule

// File: rtl/spi_hdr_decoder.sv
module spi_hdr_decoder
    import spi_front_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_active,
    input  logic                 rise,
    input  logic                 si_bit,
    input  logic                 hold_act,
    output phase_e               phase,
    output logic                 cmd_valid,
    output cmd_kind_e            cmd_kind,
    output logic [ADDR_BITS-1:0] cmd_addr
);
    logic [HDR_BITS-1:0] hdr_sh;
    logic [HDR_BITS-1:0] hdr_next;
    logic [CNT_W-1:0]    hdr_cnt;
    cmd_kind_e           kind_q;
    cmd_kind_e           op_kind;

    assign hdr_next = {hdr_sh[HDR_BITS-2:0], si_bit};
    assign op_kind  = decode_op(hdr_next[OP_BITS-1:0]);

    always_ff @(posedge clk) begin
        if (rst || !cs_active) begin
            phase     <= PH_HDR;
            hdr_sh    <= '0;
            hdr_cnt   <= '0;
            kind_q    <= CMD_NONE;
            cmd_valid <= 1'b0;
            cmd_kind  <= CMD_NONE;
            cmd_addr  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (rise && phase == PH_HDR) begin
                hdr_sh  <= hdr_next;
                hdr_cnt <= hdr_cnt + 1'b1;
                if (hdr_cnt == CNT_W'(OP_BITS - 1)) begin
                    if (op_kind == CMD_NONE) phase  <= PH_IGNORE;
                    else                     kind_q <= op_kind;
                end
                if (hdr_cnt == CNT_W'(HDR_BITS - 1)) begin
                    phase     <= PH_STREAM;
                    cmd_valid <= 1'b1;
                    cmd_kind  <= kind_q;
                    cmd_addr  <= hdr_next[ADDR_BITS-1:0];
                end
            end
        end
    end

    AST_CMD_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid); // R2

    AST_IGNORE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IGNORE && cs_active) |=> (phase == PH_IGNORE && !cmd_valid)); // R7

    AST_HOLD_FREEZES_HDR: assert property (@(posedge clk) disable iff (rst)
        (hold_act && cs_active) |=> $stable(hdr_cnt)); // R9

endmodule

// File: rtl/spi_stream_tx.sv
module spi_stream_tx
    import spi_front_pkg::*;
#(
    parameter int               ADDR_W = 8,
    parameter logic [BYTE_W-1:0] MFR_ID = 8'hC2,
    parameter logic [BYTE_W-1:0] DEV_ID = 8'h3D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_active,
    input  logic              fall,
    input  logic              hold_act,
    input  phase_e            phase,
    input  logic              cmd_valid,
    input  cmd_kind_e         cmd_kind,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [BYTE_W-1:0] mem_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              so,
    output logic              so_en
);
    logic [ADDR_W-1:0] ptr;
    logic              id_odd;
    cmd_kind_e         kind_q;
    logic [BYTE_W-2:0] sh;
    logic [BIT_W-1:0]  bit_i;
    logic              so_bit;
    logic              started;
    logic [BYTE_W-1:0] next_byte;

    always_comb begin
        if (kind_q == CMD_ID) next_byte = id_odd ? DEV_ID : MFR_ID;
        else                  next_byte = mem_data;
    end

    always_ff @(posedge clk) begin
        if (rst || !cs_active) begin
            ptr     <= '0;
            id_odd  <= 1'b0;
            kind_q  <= CMD_NONE;
            sh      <= '0;
            bit_i   <= '0;
            so_bit  <= 1'b0;
            started <= 1'b0;
        end else if (cmd_valid) begin
            ptr    <= start_addr;
            id_odd <= start_addr[0];
            kind_q <= cmd_kind;
        end else if (fall && phase == PH_STREAM) begin
            if (bit_i == '0) begin
                so_bit  <= next_byte[BYTE_W-1];
                sh      <= next_byte[BYTE_W-2:0];
                ptr     <= ptr + 1'b1;
                id_odd  <= ~id_odd;
                started <= 1'b1;
            end else begin
                so_bit <= sh[BYTE_W-2];
                sh     <= {sh[BYTE_W-3:0], 1'b0};
            end
            bit_i <= bit_i + 1'b1;
        end
    end

    assign mem_addr = ptr;
    assign so       = so_bit;
    assign so_en    = started & cs_active & ~hold_act;

    AST_SO_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (cs_active && !(fall && phase == PH_STREAM)) |=> $stable(so_bit)); // R3

endmodule

// File: rtl/flash_array_model.sv
module flash_array_model
    import spi_front_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        rd_data <= fill_byte(16'(addr));
    end
endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front
    import spi_front_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  MFR_ID      = 8'hC2,
    parameter logic [7:0]  DEV_ID      = 8'h3D
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        sck,
    input  logic        si,
    input  logic        hold_n,
    output logic        so,
    output logic        so_en,
    output logic        cmd_valid,
    output logic [1:0]  cmd_kind,
    output logic [23:0] cmd_addr
);
    link_s             lk;
    phase_e            phase;
    cmd_kind_e         kind_e;
    logic [ADDR_W-1:0] mem_addr;
    logic [BYTE_W-1:0] mem_data;

    spi_link_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n), .lk(lk)
    );

    spi_hdr_decoder u_hdr (
        .clk(clk), .rst(rst), .cs_active(lk.cs_active), .rise(lk.rise), .si_bit(lk.si),
        .hold_act(lk.hold_act), .phase(phase), .cmd_valid(cmd_valid), .cmd_kind(kind_e),
        .cmd_addr(cmd_addr)
    );

    spi_stream_tx #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_tx (
        .clk(clk), .rst(rst), .cs_active(lk.cs_active), .fall(lk.fall), .hold_act(lk.hold_act),
        .phase(phase), .cmd_valid(cmd_valid), .cmd_kind(kind_e),
        .start_addr(cmd_addr[ADDR_W-1:0]), .mem_data(mem_data), .mem_addr(mem_addr),
        .so(so), .so_en(so_en)
    );

    flash_array_model #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .addr(mem_addr), .rd_data(mem_data)
    );

    assign cmd_kind = 2'(kind_e);

    AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !lk.cs_active |=> (phase == PH_HDR && !so_en)); // R10

    AST_KIND_KNOWN: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (kind_e == CMD_READ || kind_e == CMD_ID)); // R7

endmodule

// File: tb/test_spi_flash_front.sv
`timescale 1ns/1ps
module test_spi_flash_front;

    localparam int H = 8;
    localparam logic [7:0] MFR = 8'hC2;
    localparam logic [7:0] DEV = 8'h3D;

    typedef struct packed {
        logic        m3;
        logic [7:0]  op;
        logic [23:0] addr;
        logic [3:0]  nb;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h03, 24'h000010, 4'd4},
        '{1'b1, 8'h03, 24'h000080, 4'd3},
        '{1'b0, 8'h03, 24'h0000FD, 4'd6},
        '{1'b1, 8'h03, 24'h1234FE, 4'd4},
        '{1'b0, 8'h90, 24'h000000, 4'd4},
        '{1'b1, 8'hAB, 24'h000001, 4'd3},
        '{1'b1, 8'h90, 24'h000001, 4'd2}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so, so_en, cmd_valid;
    logic [1:0] cmd_kind;
    logic [23:0] cmd_addr;

    int n_chk = 0, n_bad = 0;
    int cmd_cnt = 0, so_cnt = 0;
    logic [1:0]  seen_kind = '0;
    logic [23:0] seen_addr = '0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_flash_front i_spi_flash_front (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .so(so), .so_en(so_en), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            cmd_cnt   <= cmd_cnt + 1;
            seen_kind <= cmd_kind;
            seen_addr <= cmd_addr;
        end
        if (so_en) so_cnt <= so_cnt + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic start_txn(input bit m3);
        sck = m3;
        tick(6);
        cs_n = 1'b0;
        tick(H);
    endtask

    task automatic end_txn(input bit m3);
        if (!m3) begin
            sck = 1'b0;
            tick(H);
        end
        cs_n = 1'b1;
        tick(H);
    endtask

    task automatic shift_byte(input logic [7:0] tx, input int hold_bit, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0;
            si  = tx[i];
            tick(H);
            if (i == hold_bit) begin
                hold_n = 1'b0;
                tick(H);
                check(so_en == 1'b0, "R9 so_en during hold", 32'(so_en), 0);
                for (int k = 0; k < 2; k++) begin
                    sck = 1'b1; si = ~tx[i]; tick(H);
                    sck = 1'b0; tick(H);
                end
                si = tx[i];
                hold_n = 1'b1;
                tick(H);
            end
            rx[i] = so;
            sck = 1'b1;
            tick(H);
        end
    endtask

    task automatic send_header(input logic [7:0] op, input logic [23:0] addr, input int hold_bit);
        logic [7:0] rx;
        shift_byte(op, -1, rx);
        shift_byte(addr[23:16], -1, rx);
        shift_byte(addr[15:8], hold_bit, rx);
        shift_byte(addr[7:0], -1, rx);
    endtask

    function automatic logic [7:0] exp_byte(input logic [7:0] op, input logic [23:0] addr, input int k);
        logic [7:0] loc;
        if (op == 8'h03) begin
            loc = addr[7:0] + 8'(k);
            return loc ^ 8'h5A;
        end
        return ((addr[0] ^ k[0]) == 1'b1) ? DEV : MFR;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        int c0, s0;
        tick(5);
        rst = 1'b0;
        tick(2);
        check(so_en == 1'b0, "R1 so_en after reset", 32'(so_en), 0);
        check(cmd_valid == 1'b0, "R1 cmd_valid after reset", 32'(cmd_valid), 0);

        // table of vectors
        for (int v = 0; v < NV; v++) begin
            c0 = cmd_cnt;
            start_txn(VECS[v].m3);
            send_header(VECS[v].op, VECS[v].addr, -1);
            tick(2);
            check(cmd_cnt == c0 + 1, "R2 one strobe", 32'(cmd_cnt - c0), 1);
            check(seen_kind == ((VECS[v].op == 8'h03) ? 2'd1 : 2'd2), "R2 kind", 32'(seen_kind),
                  (VECS[v].op == 8'h03) ? 1 : 2);
            check(seen_addr == VECS[v].addr, "R2 addr", 32'(seen_addr), 32'(VECS[v].addr));
            for (int k = 0; k < int'(VECS[v].nb); k++) begin
                logic [7:0] e;
                e = exp_byte(VECS[v].op, VECS[v].addr, k);
                shift_byte(8'h00, -1, rx);
                if (VECS[v].op != 8'h03)
                    check(rx == e, "R6 id byte", 32'(rx), 32'(e));
                else if (int'(VECS[v].addr[7:0]) + k > 255)
                    check(rx == e, "R4 read wrap", 32'(rx), 32'(e));
                else if (VECS[v].m3)
                    check(rx == e, "R5 mode-3 read", 32'(rx), 32'(e));
                else
                    check(rx == e, "R3 read data", 32'(rx), 32'(e));
                check(so_en == 1'b1, "R3 so_en streaming", 32'(so_en), 1);
            end
            end_txn(VECS[v].m3);
            check(so_en == 1'b0, "R10 so_en after deselect", 32'(so_en), 0);
        end

        // unknown command code
        c0 = cmd_cnt; s0 = so_cnt;
        start_txn(1'b0);
        send_header(8'h05, 24'h000020, -1);
        shift_byte(8'h00, -1, rx);
        shift_byte(8'h00, -1, rx);
        end_txn(1'b0);
        check(cmd_cnt == c0, "R7 no strobe", 32'(cmd_cnt - c0), 0);
        check(so_cnt == s0, "R7 so_en stays low", 32'(so_cnt - s0), 0);

        // truncated header
        c0 = cmd_cnt;
        start_txn(1'b1);
        shift_byte(8'h03, -1, rx);
        shift_byte(8'h00, -1, rx);
        shift_byte(8'h44, -1, rx);
        end_txn(1'b1);
        check(cmd_cnt == c0, "R8 discarded", 32'(cmd_cnt - c0), 0);
        start_txn(1'b0);
        send_header(8'h03, 24'h000033, -1);
        shift_byte(8'h00, -1, rx);
        end_txn(1'b0);
        check(seen_addr == 24'h000033, "R8 next header clean", 32'(seen_addr), 32'h33);
        check(rx == (8'h33 ^ 8'h5A), "R8 next read data", 32'(rx), 32'(8'h33 ^ 8'h5A));

        // hold inside address byte and inside data byte
        start_txn(1'b0);
        send_header(8'h03, 24'h000040, 4);
        tick(2);
        check(seen_addr == 24'h000040, "R9 header across hold", 32'(seen_addr), 32'h40);
        shift_byte(8'h00, 3, rx);
        check(rx == (8'h40 ^ 8'h5A), "R9 data across hold", 32'(rx), 32'(8'h40 ^ 8'h5A));
        shift_byte(8'h00, 6, rx);
        check(rx == (8'h41 ^ 8'h5A), "R9 next byte after hold", 32'(rx), 32'(8'h41 ^ 8'h5A));
        end_txn(1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule